// File: doc/BRIEF.md
# Dual-Clock Receive Byte FIFO with Fill and Idle Interrupts

This block sits between a serial receiver and a processor. The receiver side pushes bytes on its own write clock. The processor side pops them on an unrelated read clock. Write and read positions cross between the two domains as Gray-coded counters, each passed through a two-stage synchroniser. The processor side sees an exact fill level, a show-ahead head byte and a 32-bit window of up to four bytes. It also has two interrupt lines.

The fill interrupt is raised while the stored count is at or above a programmable level. The idle interrupt is raised when a few bytes sit below that level and nothing has happened to the buffer for a programmable number of read-clock cycles, so stragglers still get collected. A write made while the buffer is full is discarded, and a sticky flag in the read domain records it until the processor clears it.

Top module: `rx_dual_clock_fifo`

## Requirements
- R1: Bytes come out in the order they were accepted. Whenever `rdEmpty` is 0, `rdData` shows the oldest stored byte.
- R2: After reset `rdEmpty` is 1, and `rdLevel`, `wideCount`, `wrFull`, `rxIrq`, `timeoutIrq` and `overflow` are all 0.
- R3: After 2**ADDR_W accepted writes with no reads, `wrFull` is 1 at the next write-clock sample. Further writes are discarded and leave the stored bytes unchanged. Once space is freed, `wrFull` returns to 0 within a few write-clock cycles.
- R4: A write made while `wrFull` is 1 sets `overflow` within a few read-clock cycles. `overflow` stays set until a one-cycle `ovfClr` pulse clears it.
- R5: With the buffer empty, `rdEn` or `wideRdEn` has no effect. The level stays 0 and the next byte written becomes the head.
- R6: Once both sides have been quiet for a few cycles, `rdLevel` equals the number of stored bytes, from 0 to 2**ADDR_W.
- R7: `rxIrq` is 1 exactly when `threshold` is non-zero and `rdLevel >= threshold`. A `threshold` of 0 disables it, and a `threshold` equal to the depth is legal.
- R8: `timeoutIrq` rises on the (L+1)-th read-clock cycle after the last level change or pop, where L is `timeoutLimit`. This applies only while the buffer is non-empty and `rxIrq` is 0. It stays high until the next pop or level change, and it drops in the cycle where that change becomes visible.
- R9: `wideCount` is min(`rdLevel`, 4). `wideData` holds the oldest byte in bits 7:0, the next in 15:8, and so on. Unused byte lanes read as zero. `wideRdEn` pops exactly `wideCount` bytes and takes precedence over `rdEn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Receiver-side clock |
| wrRstN | input | 1 | Asynchronous active-low reset, write domain |
| wrEn | input | 1 | Push request |
| wrData | input | 8 | Byte to push |
| wrFull | output | 1 | No room, push is discarded |
| rdClk | input | 1 | Processor-side clock |
| rdRstN | input | 1 | Asynchronous active-low reset, read domain |
| rdEn | input | 1 | Pop one byte |
| rdData | output | 8 | Oldest stored byte |
| rdEmpty | output | 1 | Nothing stored |
| wideRdEn | input | 1 | Pop `wideCount` bytes |
| wideData | output | 32 | Up to four oldest bytes, oldest in bits 7:0 |
| wideCount | output | 3 | Valid bytes in `wideData` (0 to 4) |
| rdLevel | output | ADDR_W+1 | Stored byte count seen by the read side |
| threshold | input | ADDR_W+1 | Fill-interrupt level, 0 disables |
| timeoutLimit | input | TMO_W | Idle cycles before the idle interrupt |
| rxIrq | output | 1 | Fill-level interrupt |
| timeoutIrq | output | 1 | Idle interrupt |
| ovfClr | input | 1 | Clears `overflow` |
| overflow | output | 1 | Sticky record of a discarded write |

## Verification
The hardest state to reach is a wide pop racing a write burst. In that state the read pointer moves by several places in one cycle while the write side still holds a stale copy of it, and `wrFull` has to be released late but never early. The bench reaches it by filling the buffer to the brim, then mixing four-byte pops, single pops and simultaneous requests against a random write stream. Two clocks that rarely line up make sure every phase of the pointer crossing occurs. A queue model checks the head byte and every valid lane of the wide window on every read cycle, and checks at every accepted push that the model had room.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int BUS_LANES = 4;
  localparam int CNT_W     = 3;

  typedef struct packed {
    logic             wrStrobe;
    logic [CNT_W-1:0] rdAvail;
  } fifoStrobe_t;
endpackage

// File: rtl/rxfifo_sync.sv
module rxfifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxfifo_datapath.sv
module rxfifo_datapath
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                   wrClk,
  input  fifoStrobe_t            strobe,
  input  logic [ADDR_W-1:0]      wrAddr,
  input  logic [7:0]             wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [7:0]             headByte,
  output logic [8*BUS_LANES-1:0] laneData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStrobe) mem[wrAddr] <= wrData;
  end

  assign headByte = mem[rdAddr];

  for (genvar g = 0; g < BUS_LANES; g++) begin : g_lane
    logic [ADDR_W-1:0] laneAddr;
    assign laneAddr = rdAddr + ADDR_W'(g);
    assign laneData[8*g +: 8] = (CNT_W'(g) < strobe.rdAvail) ? mem[laneAddr] : 8'h00;
  end
endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  output logic              wrFull,
  output logic [ADDR_W-1:0] wrAddr,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  input  logic              wideRdEn,
  input  logic [ADDR_W:0]   threshold,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              ovfClr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdEmpty,
  output logic [ADDR_W:0]   rdLevel,
  output logic              rxIrq,
  output logic              timeoutIrq,
  output logic              overflow,
  output fifoStrobe_t       strobe
);
  localparam int PTR_W = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    for (int i = 0; i < PTR_W; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  // write domain
  logic [PTR_W-1:0] wrBin, wrGray, rdGraySync;
  logic             push, ovfTog;

  assign wrFull = (wrGray == {~rdGraySync[PTR_W-1:PTR_W-2], rdGraySync[PTR_W-3:0]});
  assign push   = wrEn && !wrFull;
  assign wrAddr = wrBin[ADDR_W-1:0];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      ovfTog <= 1'b0;
    end else begin
      if (push) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
      if (wrEn && wrFull) ovfTog <= ~ovfTog;
    end
  end

  // read domain
  logic [PTR_W-1:0] rdBin, rdPubBin, rdPubGray, wrGraySync, level, levelPrev;
  logic [CNT_W-1:0] avail, popCnt;
  logic [TMO_W-1:0] idleCnt;
  logic             ovfTogSync, ovfTogSeen;

  rxfifo_sync #(.W(PTR_W), .STAGES(2)) u_wrPtrSync (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync)
  );
  rxfifo_sync #(.W(PTR_W), .STAGES(2)) u_rdPtrSync (
    .clk(wrClk), .rstN(wrRstN), .d(rdPubGray), .q(rdGraySync)
  );
  rxfifo_sync #(.W(1), .STAGES(2)) u_ovfSync (
    .clk(rdClk), .rstN(rdRstN), .d(ovfTog), .q(ovfTogSync)
  );

  assign level   = fromGray(wrGraySync) - rdBin;
  assign rdLevel = level;
  assign rdEmpty = (level == '0);
  assign rdAddr  = rdBin[ADDR_W-1:0];
  assign avail   = (level >= PTR_W'(BUS_LANES)) ? CNT_W'(BUS_LANES) : CNT_W'(level);
  assign popCnt  = wideRdEn ? avail : CNT_W'(rdEn && !rdEmpty);

  assign rxIrq      = (threshold != '0) && (level >= threshold);
  assign timeoutIrq = !rdEmpty && !rxIrq && (level == levelPrev) && (idleCnt == timeoutLimit);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin      <= '0;
      rdPubBin   <= '0;
      rdPubGray  <= '0;
      levelPrev  <= '0;
      idleCnt    <= '0;
      ovfTogSeen <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      rdBin <= rdBin + PTR_W'(popCnt);
      // published pointer steps one place per cycle so its Gray code flips one bit
      if (rdPubBin != rdBin) begin
        rdPubBin  <= rdPubBin + 1'b1;
        rdPubGray <= toGray(rdPubBin + 1'b1);
      end
      levelPrev <= level;
      if (rdEmpty || (popCnt != '0) || (level != levelPrev)) idleCnt <= '0;
      else if (idleCnt != timeoutLimit)                      idleCnt <= idleCnt + 1'b1;
      ovfTogSeen <= ovfTogSync;
      if (ovfTogSync != ovfTogSeen) overflow <= 1'b1;
      else if (ovfClr)              overflow <= 1'b0;
    end
  end

  assign strobe.wrStrobe = push;
  assign strobe.rdAvail  = avail;
endmodule

// File: rtl/rx_dual_clock_fifo.sv
module rx_dual_clock_fifo
  import rxfifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int TMO_W  = 8
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              rdEmpty,
  input  logic              wideRdEn,
  output logic [31:0]       wideData,
  output logic [2:0]        wideCount,
  output logic [ADDR_W:0]   rdLevel,
  input  logic [ADDR_W:0]   threshold,
  input  logic [TMO_W-1:0]  timeoutLimit,
  output logic              rxIrq,
  output logic              timeoutIrq,
  input  logic              ovfClr,
  output logic              overflow
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  rxfifo_ctrl #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrFull(wrFull), .wrAddr(wrAddr),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .wideRdEn(wideRdEn),
    .threshold(threshold), .timeoutLimit(timeoutLimit), .ovfClr(ovfClr),
    .rdAddr(rdAddr), .rdEmpty(rdEmpty), .rdLevel(rdLevel), .rxIrq(rxIrq),
    .timeoutIrq(timeoutIrq), .overflow(overflow), .strobe(strobe)
  );

  rxfifo_datapath #(.ADDR_W(ADDR_W)) u_data (
    .wrClk(wrClk), .strobe(strobe), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .headByte(rdData), .laneData(wideData)
  );

  assign wideCount = strobe.rdAvail;
endmodule

// File: rtl/rx_dual_clock_fifo_chk.sv
module rx_dual_clock_fifo_chk #(
  parameter int ADDR_W = 4
) (
  input logic              wrClk,
  input logic              wrRstN,
  input logic              rdClk,
  input logic              rdRstN,
  input logic              wrFull,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              rdEmpty,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [ADDR_W:0]   rdLevel,
  input logic [2:0]        wideCount,
  input logic [ADDR_W:0]   threshold,
  input logic              rxIrq,
  input logic              timeoutIrq,
  input logic              ovfClr,
  input logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;

  p_full_holds_wrptr_r3: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull |=> $stable(wrAddr));

  p_empty_holds_rdptr_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEmpty |=> $stable(rdAddr));

  p_level_bound_r6: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdLevel <= (ADDR_W+1)'(DEPTH));

  p_wide_count_bound_r9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (wideCount <= 3'd4) && ({{(ADDR_W-2){1'b0}}, wideCount} <= rdLevel));

  p_wide_nonzero_r9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdEmpty |-> (wideCount != 3'd0));

  p_irq_level_r7: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rxIrq |-> (rdLevel >= threshold) && !rdEmpty);

  p_timeout_excl_r8: assert property (@(posedge rdClk) disable iff (!rdRstN)
    timeoutIrq |-> !rxIrq && !rdEmpty);

  p_ovf_clear_r4: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $fell(overflow) |-> $past(ovfClr));
endmodule

bind rx_dual_clock_fifo rx_dual_clock_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
  .wrFull(wrFull), .wrAddr(wrAddr), .rdEmpty(rdEmpty), .rdAddr(rdAddr),
  .rdLevel(rdLevel), .wideCount(wideCount), .threshold(threshold),
  .rxIrq(rxIrq), .timeoutIrq(timeoutIrq), .ovfClr(ovfClr), .overflow(overflow)
);

// File: tb/tb_rx_dual_clock_fifo.sv
`timescale 1ns/100ps
module tb_rx_dual_clock_fifo;
  localparam int ADDR_W = 4;
  localparam int TMO_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic wrEn = 0, rdEn = 0, wideRdEn = 0, ovfClr = 0;
  logic [7:0] wrData = 0;
  logic [ADDR_W:0] threshold = 0;
  logic [TMO_W-1:0] timeoutLimit = 8'd200;
  logic wrFull, rdEmpty, rxIrq, timeoutIrq, overflow;
  logic [7:0] rdData;
  logic [31:0] wideData;
  logic [2:0] wideCount;
  logic [ADDR_W:0] rdLevel;

  always #5 wrClk = ~wrClk;
  always #3.5 rdClk = ~rdClk;

  rx_dual_clock_fifo #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) dut (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty),
    .wideRdEn(wideRdEn), .wideData(wideData), .wideCount(wideCount), .rdLevel(rdLevel),
    .threshold(threshold), .timeoutLimit(timeoutLimit), .rxIrq(rxIrq),
    .timeoutIrq(timeoutIrq), .ovfClr(ovfClr), .overflow(overflow)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] model[$];
  logic sFull = 0, sEmpty = 1;
  logic [2:0] sWide = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model: push on write edges, pop on read edges
  always @(negedge wrClk) sFull = wrFull;
  always @(posedge wrClk) begin
    if (wrRstN && wrEn && !sFull) begin
      check(model.size() < DEPTH, "R3", "push accepted with model full", model.size(), DEPTH - 1);
      model.push_back(wrData);
    end
  end
  always @(posedge rdClk) begin
    if (rdRstN) begin
      if (wideRdEn) begin
        for (int i = 0; i < sWide; i++) if (model.size() > 0) void'(model.pop_front());
      end else if (rdEn && !sEmpty) begin
        if (model.size() > 0) void'(model.pop_front());
      end
    end
  end

  // per-cycle comparison on the read side
  always @(negedge rdClk) begin
    sEmpty = rdEmpty;
    sWide  = wideCount;
    if (rdRstN && wrRstN && !done) begin
      check(rdLevel <= model.size(), "R6", "level above stored count", rdLevel, model.size());
      check(wideCount == ((rdLevel >= 4) ? 3'd4 : 3'(rdLevel)), "R9", "wideCount", wideCount,
            (rdLevel >= 4) ? 4 : rdLevel);
      if (!rdEmpty) begin
        if (model.size() == 0) check(0, "R1", "data shown with model empty", rdData, 0);
        else check(rdData == model[0], "R1", "head byte", rdData, model[0]);
      end
      for (int i = 0; i < 4; i++) begin
        if (i < wideCount && i < model.size())
          check(wideData[8*i +: 8] == model[i], "R9", "wide lane", wideData[8*i +: 8], model[i]);
        else if (i >= wideCount)
          check(wideData[8*i +: 8] == 8'h00, "R9", "unused lane", wideData[8*i +: 8], 0);
      end
    end
  end

  task automatic writeBurst(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk); wrEn = 1; wrData = base + 8'(i);
    end
    @(negedge wrClk); wrEn = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge wrClk);
    repeat (10) @(negedge rdClk);
  endtask

  task automatic popOne();
    @(negedge rdClk); rdEn = 1;
    @(negedge rdClk); rdEn = 0;
  endtask

  task automatic wideRead(input bit alsoSingle);
    @(negedge rdClk); wideRdEn = 1; rdEn = alsoSingle;
    @(negedge rdClk); wideRdEn = 0; rdEn = 0;
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    int n;
    repeat (4) @(negedge wrClk);
    wrRstN = 1; rdRstN = 1;
    @(negedge rdClk);
    // R2 reset state
    check(rdEmpty == 1, "R2", "rdEmpty", rdEmpty, 1);
    check(rdLevel == 0, "R2", "rdLevel", rdLevel, 0);
    check(wideCount == 0, "R2", "wideCount", wideCount, 0);
    check(wrFull == 0, "R2", "wrFull", wrFull, 0);
    check(rxIrq == 0 && timeoutIrq == 0, "R2", "irqs", {rxIrq, timeoutIrq}, 0);
    check(overflow == 0, "R2", "overflow", overflow, 0);

    // R6/R7 level and fill interrupt
    threshold = 4;
    writeBurst(5, 8'h10);
    settle(); repeat (20) @(negedge rdClk);
    check(rdLevel == 5, "R6", "level after five writes", rdLevel, 5);
    check(rxIrq == 1, "R7", "irq at level 5 thr 4", rxIrq, 1);
    check(timeoutIrq == 0, "R8", "no idle irq above threshold", timeoutIrq, 0);
    check(rdData == 8'h10, "R1", "first byte", rdData, 8'h10);
    popOne(); popOne();
    check(rdLevel == 3 && rxIrq == 0, "R7", "irq low at level 3", {rdLevel, rxIrq}, {5'd3, 1'b0});
    check(rdData == 8'h12, "R1", "third byte", rdData, 8'h12);

    // R8 idle interrupt timing
    timeoutLimit = 6;
    popOne();
    n = 0;
    while (!timeoutIrq && n < 40) begin @(negedge rdClk); n++; end
    check(n == 7, "R8", "idle irq latency", n, 7);
    repeat (5) @(negedge rdClk);
    check(timeoutIrq == 1, "R8", "idle irq held", timeoutIrq, 1);
    popOne();
    check(timeoutIrq == 0, "R8", "idle irq drops on pop", timeoutIrq, 0);
    threshold = 0;
    @(negedge rdClk);
    check(rxIrq == 0, "R7", "threshold 0 disables", rxIrq, 0);

    // R5 reads while empty
    popOne();
    check(rdEmpty == 1, "R5", "empty after drain", rdEmpty, 1);
    popOne(); wideRead(0);
    check(rdLevel == 0, "R5", "level unchanged by empty reads", rdLevel, 0);
    writeBurst(1, 8'hA5);
    settle();
    check(rdData == 8'hA5 && rdLevel == 1, "R5", "new head after empty reads", rdData, 8'hA5);
    popOne();

    // R3/R4 fill to the brim and overflow
    threshold = DEPTH;
    writeBurst(DEPTH + 3, 8'h40);
    check(wrFull == 1, "R3", "full after depth writes", wrFull, 1);
    settle();
    check(rdLevel == DEPTH, "R3", "level at depth", rdLevel, DEPTH);
    check(rxIrq == 1, "R7", "irq with threshold = depth", rxIrq, 1);
    check(rdData == 8'h40, "R3", "dropped writes leave head", rdData, 8'h40);
    check(overflow == 1, "R4", "overflow set", overflow, 1);
    @(negedge rdClk); ovfClr = 1;
    @(negedge rdClk); ovfClr = 0;
    check(overflow == 0, "R4", "overflow cleared", overflow, 0);
    repeat (10) @(negedge rdClk);
    check(overflow == 0, "R4", "overflow stays clear", overflow, 0);

    // R9 wide reads
    check(wideCount == 4 && wideData == 32'h43424140, "R9", "wide window", wideData, 32'h43424140);
    wideRead(0);
    check(rdLevel == 12 && rdData == 8'h44, "R9", "wide pop of four", {rdLevel, rdData}, {5'd12, 8'h44});
    settle();
    check(wrFull == 0, "R3", "full released", wrFull, 0);
    wideRead(1);
    check(rdLevel == 8 && rdData == 8'h48, "R9", "wide beats single", {rdLevel, rdData}, {5'd8, 8'h48});
    wideRead(0); popOne();
    check(wideCount == 3 && wideData == 32'h004F4E4D, "R9", "partial window", wideData, 32'h004F4E4D);
    wideRead(0);
    check(rdEmpty == 1, "R9", "partial wide pop drains", rdEmpty, 1);

    // random traffic
    threshold = 8;
    fork
      begin
        for (int i = 0; i < 800; i++) begin
          @(negedge wrClk); wrEn = ($urandom % 2) == 0; wrData = 8'($urandom);
        end
        @(negedge wrClk); wrEn = 0;
      end
      begin
        for (int i = 0; i < 1100; i++) begin
          @(negedge rdClk);
          wideRdEn = ($urandom % 6) == 0;
          rdEn = ($urandom % 3) == 0;
          ovfClr = ($urandom % 50) == 0;
        end
        @(negedge rdClk); wideRdEn = 0; rdEn = 0; ovfClr = 0;
      end
    join
    settle();
    for (int i = 0; i < 10 && !rdEmpty; i++) wideRead(0);
    settle();
    check(rdEmpty == 1 && model.size() == 0, "R1", "drained after traffic", model.size(), 0);
    check(rdLevel == 0, "R6", "level zero after drain", rdLevel, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule